// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a free-standing tick timer that a processor controls through a small special-register port. It holds two 32-bit registers. The count register advances once per clock. The mode register carries a two-bit operating mode, an interrupt-enable bit, a sticky interrupt-pending bit and a 28-bit period. On each clock the low 28 bits of the count are compared against the period. What happens on a match depends on the mode: the count restarts from zero, the count halts, or the count runs on.

When interrupts are enabled, a match event sets the pending bit. That bit stays set until software writes the mode register with the bit cleared. The block raises its tick request output only while the pending bit is set and an external supervisor enable input is high. The register port has no stream traffic. It is a plain address, write strobe, write data and read data interface with no back-pressure. A write completes in the clock cycle it is presented, and a read is combinational on the address.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset both registers read as zero and `tick_req` is low.
- R2: Address 0 selects the count register and address 1 the mode register. Mode register fields: bits 31:30 mode (0 off, 1 auto-restart, 2 halt-at-match, 3 free-run), bit 29 interrupt enable, bit 28 pending, bits 27:0 period. A read returns the stored value.
- R3: A match is the low 28 bits of the count equal to the period. Count bits 31:28 do not take part in the comparison.
- R4: In auto-restart mode a match loads zero into the count at that clock edge, and counting continues from zero.
- R5: In halt-at-match mode the count stops at the matching value and produces one match event. It stays stopped until the count register is written.
- R6: In free-run mode the count increments through the match value without being reset.
- R7: In off mode the count holds its value and no match event is produced.
- R8: A match event with interrupt enable set sets the pending bit. The bit stays set until a mode register write clears it.
- R9: `tick_req` is high exactly when the pending bit is set and `tick_exc_en` is high.
- R10: A mode register write that selects auto-restart clears the count to zero.
- R11: A count register write loads the written value, and counting resumes from that value in the following cycles.
- R12: A register write in the same cycle as a hardware update of that register wins. A count write beats an auto-restart clear. A mode write beats a pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tick_exc_en | input | 1 | External tick exception enable |
| tick_req | output | 1 | Tick exception request |

## Verification
On every cycle the assertions check four things: the count holding in off mode and after a halt, the restart to zero after an auto-restart match, a count write landing as written, and the pending bit staying set unless the mode register is written. The bench scenarios cover the rest: the exact cycle on which each mode reaches or passes its period, the 28-bit width of the comparison, and the outcome of a write that collides with a match. These need a specific stimulus history and known expected values.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W  = 32;
  localparam int PER_W   = DATA_W - 4;
  localparam int MODE_HI = DATA_W - 1;
  localparam int MODE_LO = DATA_W - 2;
  localparam int IE_BIT  = DATA_W - 3;
  localparam int IP_BIT  = DATA_W - 4;

  typedef enum logic [1:0] {
    TM_OFF  = 2'd0,
    TM_AUTO = 2'd1,
    TM_HALT = 2'd2,
    TM_FREE = 2'd3
  } tmode_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic [PER_W-1:0]  period,
  input  logic              ld_cnt,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              ld_zero,
  output logic [DATA_W-1:0] cnt_q,
  output logic              match_evt
);
  logic halted_q;
  logic match;

  assign match     = (cnt_q[PER_W-1:0] == period);
  assign match_evt = match && (mode != TM_OFF) && !((mode == TM_HALT) && halted_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else if (ld_cnt) begin
      cnt_q    <= ld_val;
      halted_q <= 1'b0;
    end else if (ld_zero) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (mode)
        TM_OFF:  cnt_q <= cnt_q;
        TM_AUTO: cnt_q <= match ? '0 : cnt_q + 1'b1;
        TM_HALT: begin
          if (halted_q) begin
            cnt_q <= cnt_q;
          end else if (match) begin
            halted_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TM_FREE: cnt_q <= cnt_q + 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7: off mode leaves the count untouched
  a_r7_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_OFF && !ld_cnt && !ld_zero) |=> $stable(cnt_q));

  // R4: auto-restart match wraps to zero
  a_r4_auto_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_AUTO && match && !ld_cnt && !ld_zero) |=> (cnt_q == '0));

  // R5: once halted the count stays put
  a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_HALT && halted_q && !ld_cnt && !ld_zero) |=> $stable(cnt_q));

  // R11: a count write lands as written
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/tick_mode_reg.sv
module tick_mode_reg
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              match_evt,
  output logic [DATA_W-1:0] mode_word,
  output tmode_e            mode,
  output logic [PER_W-1:0]  period,
  output logic              pending
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= wr_val;
    end else if (match_evt && word_q[IE_BIT]) begin
      word_q[IP_BIT] <= 1'b1;
    end
  end

  assign mode_word = word_q;
  assign mode      = tmode_e'(word_q[MODE_HI:MODE_LO]);
  assign period    = word_q[PER_W-1:0];
  assign pending   = word_q[IP_BIT];

  // R8: pending is sticky until software rewrites the register
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !wr_en) |=> pending);
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int COUNT_ADDR = 0,
  parameter int MODE_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tick_exc_en,
  output logic              tick_req
);
  localparam logic [ADDR_W-1:0] CNT_SEL  = ADDR_W'(COUNT_ADDR);
  localparam logic [ADDR_W-1:0] MODE_SEL = ADDR_W'(MODE_ADDR);

  logic              wr_cnt, wr_mode, ld_zero, match_evt, pending;
  logic [DATA_W-1:0] cnt_q, mode_word;
  tmode_e            mode;
  logic [PER_W-1:0]  period;

  assign wr_cnt  = reg_we && (reg_addr == CNT_SEL);
  assign wr_mode = reg_we && (reg_addr == MODE_SEL);
  assign ld_zero = wr_mode && (reg_wdata[MODE_HI:MODE_LO] == TM_AUTO);

  tick_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_mode),
    .wr_val    (reg_wdata),
    .match_evt (match_evt),
    .mode_word (mode_word),
    .mode      (mode),
    .period    (period),
    .pending   (pending)
  );

  tick_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .period    (period),
    .ld_cnt    (wr_cnt),
    .ld_val    (reg_wdata),
    .ld_zero   (ld_zero),
    .cnt_q     (cnt_q),
    .match_evt (match_evt)
  );

  always_comb begin
    if (reg_addr == CNT_SEL)       reg_rdata = cnt_q;
    else if (reg_addr == MODE_SEL) reg_rdata = mode_word;
    else                           reg_rdata = '0;
  end

  assign tick_req = pending && tick_exc_en;

  // R10: selecting auto-restart by a mode write zeroes the count
  a_r10_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_zero && !wr_cnt) |=> (cnt_q == '0));
endmodule

// File: tb/sim_tick_timer_unit.sv
module sim_tick_timer_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] mode_word;
    logic [31:0] load;
    int          steps;
    logic [31:0] exp_cnt;
    logic        exp_ip;
  } vec_t;

  // R4 R5 R6 R7 R3 scenarios
  localparam vec_t VECS [9] = '{
    '{32'h6000_0005, 32'd2,         3, 32'd3,         1'b0}, // R10 auto, load overridden
    '{32'h6000_0005, 32'd0,         6, 32'd0,         1'b1}, // R4 wrap + pending
    '{32'h4000_0005, 32'd0,         8, 32'd2,         1'b0}, // R4 wrap, ie off
    '{32'hA000_0004, 32'd1,        10, 32'd4,         1'b1}, // R5 halt at match
    '{32'hA000_0004, 32'd6,         5, 32'd11,        1'b0}, // R5 above period
    '{32'hE000_0003, 32'd0,         7, 32'd7,         1'b1}, // R6 runs through
    '{32'h2000_0009, 32'd9,         5, 32'd9,         1'b0}, // R7 off holds
    '{32'hC000_0002, 32'd0,         4, 32'd4,         1'b0}, // R6 ie off
    '{32'hE000_0003, 32'h1000_0001, 3, 32'h1000_0004, 1'b1}  // R3 low bits only
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_exc_en = 1'b0;
  logic        tick_req;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  tick_timer_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_exc_en(tick_exc_en), .tick_req(tick_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one rising edge passes inside
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, rv); check("R1 count", rv, 32'd0);
    rd(4'd1, rv); check("R1 mode", rv, 32'd0);
    check("R1 req", {31'd0, tick_req}, 32'd0);

    foreach (VECS[i]) begin
      wr(4'd1, {2'b00, VECS[i].mode_word[29:0]});
      wr(4'd0, VECS[i].load);
      wr(4'd1, VECS[i].mode_word);
      step(VECS[i].steps);
      rd(4'd0, rv);
      check($sformatf("R4-7 vec%0d count", i), rv, VECS[i].exp_cnt);
      rd(4'd1, rv);
      check($sformatf("R2 R8 vec%0d mode", i), rv,
            VECS[i].mode_word | (32'(VECS[i].exp_ip) << 28));
    end

    // R9 request gating, pending set from auto match
    wr(4'd1, 32'h0000_0005);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h6000_0005);
    step(6);
    check("R9 req low without enable", {31'd0, tick_req}, 32'd0);
    tick_exc_en = 1'b1; #1;
    check("R9 req high", {31'd0, tick_req}, 32'd1);
    step(4);
    check("R8 pending sticky", {31'd0, tick_req}, 32'd1);
    wr(4'd1, 32'h2000_0005);   // off mode, pending cleared
    check("R8 pending cleared", {31'd0, tick_req}, 32'd0);
    tick_exc_en = 1'b0;

    // R5 halted count resumes after count write (R11)
    wr(4'd1, 32'h2000_0004);
    wr(4'd0, 32'd2);
    wr(4'd1, 32'hA000_0004);
    step(8);
    rd(4'd0, rv); check("R5 halted", rv, 32'd4);
    wr(4'd0, 32'd0);
    step(2);
    rd(4'd0, rv); check("R11 resume after load", rv, 32'd2);

    // R12 count write beats auto-restart clear at match edge
    wr(4'd1, 32'h0000_0003);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h4000_0003);
    step(3);
    wr(4'd0, 32'd1);
    rd(4'd0, rv); check("R12 count write wins", rv, 32'd1);

    // R12 mode write beats pending set at match edge
    wr(4'd1, 32'h2000_0002);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'hE000_0002);
    step(2);
    wr(4'd1, 32'hE000_0002);
    rd(4'd1, rv); check("R12 mode write wins", rv, 32'hE000_0002);
    rd(4'd0, rv); check("R6 keeps counting", rv, 32'd3);

    // R2 unmapped address reads zero
    rd(4'd7, rv); check("R2 unmapped", rv, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule